// File: doc/BRIEF.md
# Sectioned Register Map with Time-Write Lock

This block holds the byte registers that sit behind a serial slave controller. A byte address space from 00h to 19h is split into five fixed sections: time (00h–06h), control/status (07h–0Bh), alarm (0Ch–11h), user memory (12h–13h) and time stamp (14h–19h). The slave controller opens a transaction by pulsing a start strobe with a byte address, then moves data one byte at a time with separate write and read strobes. After every byte the internal address advances by one. When it passes the top of the section where it currently lies, it returns to the bottom of that same section, so a burst never leaves its section. Moving to another section takes a new transaction.

Address 09h is a hole: it has no storage, it reads as 00h and writes to it change nothing. Addresses above 19h behave the same way, and the pointer stays on such an address instead of advancing. The seven time registers accept writes only while bit 4 of register 07h is 1. Register 07h itself is always writable. Read data is registered and stays on the output until the next read.

Top module: `rfs_regmap`

## Requirements
- R1: After reset every register reads 00h and `rd_data` is 00h.
- R2: A write strobe to a present address outside the time section stores `wr_data`. A later read of that address returns the byte on `rd_data` in the cycle after the read strobe.
- R3: Each write or read strobe advances the address by one for the next strobe of the same transaction.
- R4: After the last address of a section, the next address is the first address of the same section: 06h→00h, 0Bh→07h, 11h→0Ch, 13h→12h, 19h→14h.
- R5: Writes to 00h–06h take effect only while bit 4 of register 07h is 1. While that bit is 0 they leave the time registers unchanged, whatever the other bits of 07h hold.
- R6: Address 09h reads as 00h. A write to it changes no register.
- R7: Addresses 1Ah–FFh read as 00h and writes to them are discarded. The pointer holds on such an address.
- R8: When `txn_start` and a strobe arrive in the same cycle, the access uses `txn_addr`.
- R9: When write and read strobes arrive together, only the write is performed, `rd_data` keeps its value and the address advances once.
- R10: `rd_data` holds its value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Opens a transaction at `txn_addr` |
| txn_addr | input | 8 | Start address of the transaction |
| wr_stb | input | 1 | Writes `wr_data` at the current address |
| wr_data | input | 8 | Write byte |
| rd_stb | input | 1 | Reads the current address into `rd_data` |
| rd_data | output | 8 | Registered read byte |

## Verification
The case hardest to reach from the ports is the wrap inside a section. It only shows after a burst has walked the whole section, and in the control section the burst rewrites the lock bit as it passes. The stimulus runs bursts two or three bytes longer than each section and starts them at several offsets. The bench model tracks the lock bit byte by byte, so writes to the time section are predicted correctly when register 07h changes in the middle of a burst. A full sweep of every address above 19h, followed by a readback of the whole map, shows that none of those writes landed.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;

    // Section bounds (behavioural: burst wrap depends on them)
    localparam int TIME_LO   = 0;
    localparam int TIME_HI   = 6;
    localparam int CTRL_LO   = 7;
    localparam int CTRL_HI   = 11;
    localparam int ALRM_LO   = 12;
    localparam int ALRM_HI   = 17;
    localparam int USER_LO   = 18;
    localparam int USER_HI   = 19;
    localparam int STMP_LO   = 20;
    localparam int STMP_HI   = 25;

    localparam int NUM_REGS  = STMP_HI + 1;
    localparam int HOLE_IDX  = 9;
    localparam int LOCK_IDX  = CTRL_LO;
    localparam int LOCK_BIT  = 4;

    typedef enum logic [2:0] {
        SEC_TIME,
        SEC_CTRL,
        SEC_ALRM,
        SEC_USER,
        SEC_STMP,
        SEC_NONE
    } sect_e;

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
    } ptr_state_t;

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] mem;
        logic [DATA_W-1:0]               rd;
    } store_state_t;

    function automatic sect_e addr_section(input logic [ADDR_W-1:0] a);
        int v;
        v = int'(a);
        if (v <= TIME_HI)      return SEC_TIME;
        else if (v <= CTRL_HI) return SEC_CTRL;
        else if (v <= ALRM_HI) return SEC_ALRM;
        else if (v <= USER_HI) return SEC_USER;
        else if (v <= STMP_HI) return SEC_STMP;
        else                   return SEC_NONE;
    endfunction

    function automatic logic [ADDR_W-1:0] sect_first(input sect_e s);
        case (s)
            SEC_TIME: return ADDR_W'(TIME_LO);
            SEC_CTRL: return ADDR_W'(CTRL_LO);
            SEC_ALRM: return ADDR_W'(ALRM_LO);
            SEC_USER: return ADDR_W'(USER_LO);
            SEC_STMP: return ADDR_W'(STMP_LO);
            default:  return '0;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] sect_last(input sect_e s);
        case (s)
            SEC_TIME: return ADDR_W'(TIME_HI);
            SEC_CTRL: return ADDR_W'(CTRL_HI);
            SEC_ALRM: return ADDR_W'(ALRM_HI);
            SEC_USER: return ADDR_W'(USER_HI);
            SEC_STMP: return ADDR_W'(STMP_HI);
            default:  return '0;
        endcase
    endfunction

endpackage

// File: rtl/rfs_sect_dec.sv
module rfs_sect_dec
    import rfs_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output sect_e             sect,
    output logic [ADDR_W-1:0] first,
    output logic [ADDR_W-1:0] last,
    output logic              in_map
);

    always_comb begin
        sect   = addr_section(addr);
        first  = sect_first(sect);
        last   = sect_last(sect);
        in_map = (sect != SEC_NONE);
    end

endmodule

// File: rtl/rfs_addr_ptr.sv
module rfs_addr_ptr
    import rfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] eff_addr
);

    ptr_state_t        st_d, st_q;
    sect_e             eff_sect;
    logic [ADDR_W-1:0] sec_first;
    logic [ADDR_W-1:0] sec_last;
    logic              in_map;

    // A start in the same cycle as a strobe acts on the new address
    assign eff_addr = start ? start_addr : st_q.ptr;

    rfs_sect_dec u_dec (
        .addr   (eff_addr),
        .sect   (eff_sect),
        .first  (sec_first),
        .last   (sec_last),
        .in_map (in_map)
    );

    always_comb begin
        st_d = st_q;
        if (step) begin
            if (!in_map)
                st_d.ptr = eff_addr;
            else if (eff_addr == sec_last)
                st_d.ptr = sec_first;
            else
                st_d.ptr = eff_addr + ADDR_W'(1);
        end else if (start) begin
            st_d.ptr = start_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // R4
    stay_in_section_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && in_map) |=> (addr_section(st_q.ptr) == $past(eff_sect)));

    // R4
    wrap_to_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && in_map && (eff_addr == sec_last)) |=> (st_q.ptr == $past(sec_first)));

    // R7
    off_map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !in_map) |=> (st_q.ptr == $past(eff_addr)));

endmodule

// File: rtl/rfs_store.sv
module rfs_store
    import rfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data
);

    store_state_t        st_d, st_q;
    logic [NUM_REGS-1:0] byte_we;
    logic                time_open;
    sect_e               sect;
    logic                present;
    logic [DATA_W-1:0]   rd_sel;

    assign sect      = addr_section(addr);
    assign present   = (sect != SEC_NONE) && (addr != ADDR_W'(HOLE_IDX));
    assign time_open = st_q.mem[LOCK_IDX][LOCK_BIT];
    assign rd_data   = st_q.rd;

    // Per-byte write enables; the hole never stores, time bytes need the lock bit
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_we
        if (i == HOLE_IDX) begin : g_hole
            assign byte_we[i] = 1'b0;
        end else if (i <= TIME_HI) begin : g_time
            assign byte_we[i] = wr_stb && time_open && (addr == ADDR_W'(i));
        end else begin : g_open
            assign byte_we[i] = wr_stb && (addr == ADDR_W'(i));
        end
    end

    always_comb begin
        rd_sel = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (addr == ADDR_W'(i))
                rd_sel = st_q.mem[i];
        end
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (byte_we[i])
                st_d.mem[i] = wr_data;
        end
        if (rd_stb && !wr_stb)
            st_d.rd = present ? rd_sel : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // R5
    time_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (sect == SEC_TIME) && !time_open) |=> $stable(st_q.mem[TIME_HI:TIME_LO]));

    // R6
    hole_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (addr == ADDR_W'(HOLE_IDX))) |=> $stable(st_q.mem));

    // R7
    absent_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && !present) |=> (rd_data == '0));

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb || wr_stb) |=> $stable(rd_data));

endmodule

// File: rtl/rfs_regmap.sv
module rfs_regmap
    import rfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data
);

    logic [ADDR_W-1:0] eff_addr;
    logic              step;

    assign step = wr_stb || rd_stb;

    rfs_addr_ptr u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (txn_start),
        .start_addr (txn_addr),
        .step       (step),
        .eff_addr   (eff_addr)
    );

    rfs_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (eff_addr),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .rd_stb  (rd_stb),
        .rd_data (rd_data)
    );

endmodule

// File: tb/test_rfs_regmap.sv
`timescale 1ns/1ps
module test_rfs_regmap;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txn_start = 1'b0;
    logic [7:0] txn_addr = '0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;

    int         n_checks = 0;
    int         n_errors = 0;
    bit         done = 1'b0;
    logic [7:0] model [0:25];
    int         bptr = 0;
    logic [7:0] last_rd = '0;

    always #4 clk = ~clk;

    rfs_regmap i_rfs_regmap (
        .clk       (clk),
        .rst_n     (rst_n),
        .txn_start (txn_start),
        .txn_addr  (txn_addr),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .rd_stb    (rd_stb),
        .rd_data   (rd_data)
    );

    function automatic int lo_of(int a);
        if (a <= 6) return 0;
        else if (a <= 11) return 7;
        else if (a <= 17) return 12;
        else if (a <= 19) return 18;
        else return 20;
    endfunction

    function automatic int hi_of(int a);
        if (a <= 6) return 6;
        else if (a <= 11) return 11;
        else if (a <= 17) return 17;
        else if (a <= 19) return 19;
        else return 25;
    endfunction

    function automatic int next_of(int a);
        if (a > 25) return a;
        return (a == hi_of(a)) ? lo_of(a) : a + 1;
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic xfer(input bit st, input int a, input bit w, input logic [7:0] wd,
                        input bit r, input string req);
        int eff;
        @(negedge clk);
        txn_start = st; txn_addr = 8'(a); wr_stb = w; wr_data = wd; rd_stb = r;
        @(negedge clk);
        txn_start = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0;
        eff = st ? a : bptr;
        if (w) begin
            if (eff <= 25 && eff != 9 && (eff > 6 || model[7][4])) model[eff] = wd;
        end else if (r) begin
            last_rd = (eff <= 25 && eff != 9) ? model[eff] : 8'h00;
        end
        check(rd_data, last_rd, req);
        bptr = next_of(eff);
    endtask

    task automatic read_all(input string req);
        for (int a = 0; a <= 25; a++) xfer(1'b1, a, 1'b0, 8'h00, 1'b1, req);
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int lo_tab [5] = '{0, 7, 12, 18, 20};
        int hi_tab [5] = '{6, 11, 17, 19, 25};
        for (int a = 0; a <= 25; a++) model[a] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, including holes and out-of-map addresses
        check(rd_data, 8'h00, "R1");
        for (int a = 0; a < 32; a++) xfer(1'b1, a, 1'b0, 8'h00, 1'b1, "R1");

        // R5: open the time section
        xfer(1'b1, 7, 1'b1, 8'h10, 1'b0, "R5");

        // R2 R3 R4: over-length bursts in every section, several start offsets
        for (int s = 0; s < 5; s++) begin
            int len;
            len = hi_tab[s] - lo_tab[s] + 1;
            for (int off = 0; off < 2; off++) begin
                int st_a;
                st_a = lo_tab[s] + (off * (len - 1));
                xfer(1'b1, st_a, 1'b1, 8'(37 * s + 11 * off + 3), 1'b0, "R8");
                for (int k = 1; k < len + 2; k++)
                    xfer(1'b0, 0, 1'b1, 8'(37 * s + 11 * off + 5 * k + 3), 1'b0, "R3");
                xfer(1'b1, hi_tab[s], 1'b0, 8'h00, 1'b1, "R4");
                for (int k = 0; k < len + 2; k++)
                    xfer(1'b0, 0, 1'b0, 8'h00, 1'b1, "R4");
            end
        end
        read_all("R2");

        // R5: lock with every other bit set, then try to write time
        xfer(1'b1, 7, 1'b1, 8'hEF, 1'b0, "R5");
        xfer(1'b1, 2, 1'b1, 8'hA5, 1'b0, "R5");
        for (int k = 0; k < 8; k++) xfer(1'b0, 0, 1'b1, 8'(8'h60 + k), 1'b0, "R5");
        for (int a = 0; a <= 6; a++) xfer(1'b1, a, 1'b0, 8'h00, 1'b1, "R5");
        xfer(1'b1, 7, 1'b1, 8'h10, 1'b0, "R5");
        xfer(1'b1, 3, 1'b1, 8'hC3, 1'b0, "R5");
        xfer(1'b1, 3, 1'b0, 8'h00, 1'b1, "R5");

        // R6: hole
        xfer(1'b1, 9, 1'b1, 8'hFF, 1'b0, "R6");
        xfer(1'b1, 9, 1'b0, 8'h00, 1'b1, "R6");
        read_all("R6");

        // R7: every address above the map
        for (int a = 26; a < 256; a++) xfer(1'b1, a, 1'b1, 8'(a ^ 8'h5A), 1'b0, "R7");
        xfer(1'b1, 8'h40, 1'b1, 8'h77, 1'b0, "R7");
        xfer(1'b0, 0, 1'b0, 8'h00, 1'b1, "R7");
        xfer(1'b0, 0, 1'b0, 8'h00, 1'b1, "R7");
        read_all("R7");

        // R9: simultaneous strobes
        xfer(1'b1, 8'h14, 1'b0, 8'h00, 1'b1, "R9");
        xfer(1'b1, 8'h12, 1'b1, 8'h5A, 1'b1, "R9");
        xfer(1'b0, 0, 1'b0, 8'h00, 1'b1, "R9");
        xfer(1'b0, 0, 1'b0, 8'h00, 1'b1, "R9");

        // R10: idle hold
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(rd_data, last_rd, "R10");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule